// File: doc/BRIEF.md
# Vector Element Window Shifter

This block joins two packed vector operands into one array of twice the register length. The low operand fills the lower element positions and the high operand fills the upper ones. The block returns a register-length window of consecutive elements that begins at a chosen element offset. A copy loop can read aligned data into two registers and then use this block to build the misaligned result, so that no memory access has to be misaligned. Neither source is modified, and the result is written to its own destination port.

The element width is chosen per operation: 8, 16 or 32 bits. The offset comes either from an immediate field or from a scalar register value, chosen by a select input. An offset equal to the element count returns the high operand unchanged. Window positions that fall past the end of the double-length array are filled with zeros. The result is registered, and a valid strobe marks it.

Top module: `vec_window_shift`

## Requirements
- R1: Output element i (i from 0 to N-1, where N = VLEN/width) equals element i+k of the double-length array, where k is the selected offset. Array elements 0..N-1 come from `src_lo` and elements N..2N-1 come from `src_hi`. Element e occupies bits [e*width +: width].
- R2: An offset of 0 produces `src_lo` exactly.
- R3: An offset of N produces `src_hi` exactly.
- R4: Output elements whose array index i+k is 2N or more are zero. Any offset of 2N or more therefore gives an all-zero result.
- R5: `ew_sel` selects the element width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. The value 3 also selects 32 bits.
- R6: When `ofs_from_reg` is 1 the offset is `reg_ofs`. When it is 0 the offset is `imm_ofs`. The offset that is not selected has no effect on the result.
- R7: `res_valid` goes high exactly one cycle after `op_valid`, and `res` carries that operation's result in the same cycle. `res_valid` is low in any cycle that does not follow an accepted operation.
- R8: When `op_valid` is low, `res` keeps its previous value.
- R9: While reset is asserted, `res_valid` is 0 and `res` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| ew_sel | input | 2 | Element width select |
| ofs_from_reg | input | 1 | 1: take offset from reg_ofs, 0: from imm_ofs |
| imm_ofs | input | OFS_W | Immediate element offset |
| reg_ofs | input | OFS_W | Scalar-register element offset |
| src_lo | input | VLEN | Low half of the double-length array |
| src_hi | input | VLEN | High half of the double-length array |
| res_valid | output | 1 | Result valid strobe |
| res | output | VLEN | Result window |

## Verification
Every operation's result and strobe are due on the first rising edge after the operation is presented, and no sooner or later. The bench drives inputs on falling edges. A behavioural model updates its expected strobe and window on each rising edge from the inputs driven just before it. The outputs are compared with the model on every falling edge, half a cycle after the registers update. Idle cycles are compared the same way, which checks that the window holds its value and the strobe drops.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic [1:0] {
    EW_B8  = 2'd0,
    EW_B16 = 2'd1,
    EW_B32 = 2'd2,
    EW_ALT = 2'd3
  } ew_e;

  // log2 of element size in bytes
  function automatic logic [1:0] ew_lg(input ew_e w);
    case (w)
      EW_B8:   ew_lg = 2'd0;
      EW_B16:  ew_lg = 2'd1;
      default: ew_lg = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/vws_ofs_sel.sv
module vws_ofs_sel
  import vws_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int OFS_W = 8
) (
  input  logic [1:0]       ew_sel,
  input  logic             ofs_from_reg,
  input  logic [OFS_W-1:0] imm_ofs,
  input  logic [OFS_W-1:0] reg_ofs,
  output logic [OFS_W-1:0] eff_ofs,
  output logic [$clog2(VLEN/4)-1:0] byte_sh,
  output logic             kill
);
  localparam int NB   = VLEN / 8;
  localparam int SH_W = $clog2(2 * NB);
  localparam int BS_W = OFS_W + 2;

  logic [BS_W-1:0] bsh_full;
  logic [1:0]      lg;

  always_comb begin
    eff_ofs  = ofs_from_reg ? reg_ofs : imm_ofs;
    lg       = ew_lg(ew_e'(ew_sel));
    bsh_full = {2'b00, eff_ofs} << lg;
    kill     = (bsh_full >= BS_W'(2 * NB));
    byte_sh  = bsh_full[SH_W-1:0];
  end
endmodule

// File: rtl/vws_funnel.sv
module vws_funnel #(
  parameter int VLEN = 128
) (
  input  logic [2*VLEN-1:0]          cat,
  input  logic [$clog2(VLEN/4)-1:0]  byte_sh,
  input  logic                       kill,
  output logic [VLEN-1:0]            win
);
  localparam int NB   = VLEN / 8;
  localparam int SH_W = $clog2(2 * NB);

  logic [2*VLEN-1:0] stg [SH_W];
  logic [VLEN-1:0]   last;

  assign stg[0] = cat;

  // logarithmic byte shifter, one stage per shift-amount bit
  for (genvar k = 0; k < SH_W - 1; k++) begin : g_stage
    localparam int AMT = 8 << k;
    always_comb begin
      stg[k+1] = byte_sh[k] ? (stg[k] >> AMT) : stg[k];
    end
  end

  // final stage keeps only the window width
  localparam int LAMT = 8 << (SH_W - 1);
  always_comb begin
    last = byte_sh[SH_W-1] ? stg[SH_W-1][LAMT +: VLEN] : stg[SH_W-1][VLEN-1:0];
    win  = kill ? '0 : last;
  end
endmodule

// File: rtl/vec_window_shift.sv
module vec_window_shift
  import vws_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       ew_sel,
  input  logic             ofs_from_reg,
  input  logic [OFS_W-1:0] imm_ofs,
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic [VLEN-1:0]  src_lo,
  input  logic [VLEN-1:0]  src_hi,
  output logic             res_valid,
  output logic [VLEN-1:0]  res
);
  localparam int SH_W = $clog2(VLEN / 4);

  logic [OFS_W-1:0] eff_ofs;
  logic [SH_W-1:0]  byte_sh;
  logic             kill;
  logic [VLEN-1:0]  win;
  logic             vld_d;
  logic [VLEN-1:0]  res_d;

  vws_ofs_sel #(.VLEN(VLEN), .OFS_W(OFS_W)) u_ofs (
    .ew_sel       (ew_sel),
    .ofs_from_reg (ofs_from_reg),
    .imm_ofs      (imm_ofs),
    .reg_ofs      (reg_ofs),
    .eff_ofs      (eff_ofs),
    .byte_sh      (byte_sh),
    .kill         (kill)
  );

  vws_funnel #(.VLEN(VLEN)) u_fun (
    .cat     ({src_hi, src_lo}),
    .byte_sh (byte_sh),
    .kill    (kill),
    .win     (win)
  );

  // next state, with the clock enable written out
  always_comb begin
    vld_d = op_valid;
    res_d = op_valid ? win : res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= vld_d;
      res       <= res_d;
    end
  end

  AST_STROBE_DUE: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> res_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> !res_valid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> $stable(res)); // R8
  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && kill) |=> (res == '0)); // R4
  AST_ZERO_OFS_LO: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && eff_ofs == '0) |=> (res == $past(src_lo))); // R2
endmodule

// File: tb/sim_vec_window_shift.sv
module sim_vec_window_shift;
  localparam int VLEN  = 128;
  localparam int OFS_W = 8;
  localparam int NB    = VLEN / 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             op_valid;
  logic [1:0]       ew_sel;
  logic             ofs_from_reg;
  logic [OFS_W-1:0] imm_ofs;
  logic [OFS_W-1:0] reg_ofs;
  logic [VLEN-1:0]  src_lo;
  logic [VLEN-1:0]  src_hi;
  logic             res_valid;
  logic [VLEN-1:0]  res;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  string exp_tag = "R9";
  logic             exp_vld;
  logic [VLEN-1:0]  exp_res;
  bit               cmp_on = 1'b0;

  always #5 clk = ~clk;

  vec_window_shift #(.VLEN(VLEN), .OFS_W(OFS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .ew_sel(ew_sel),
    .ofs_from_reg(ofs_from_reg), .imm_ofs(imm_ofs), .reg_ofs(reg_ofs),
    .src_lo(src_lo), .src_hi(src_hi), .res_valid(res_valid), .res(res)
  );

  // element view: element e of the 2N array, zero past the end
  function automatic logic [VLEN-1:0] model(input logic [1:0] w, input int k,
                                            input logic [VLEN-1:0] lo,
                                            input logic [VLEN-1:0] hi);
    int esz;
    int n;
    logic [VLEN-1:0] r;
    esz = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;   // R5
    n   = VLEN / esz;
    r   = '0;
    for (int i = 0; i < n; i++) begin
      int e;
      e = i + k;
      for (int b = 0; b < esz; b++) begin
        if (e < n)          r[i*esz + b] = lo[e*esz + b];
        else if (e < 2 * n) r[i*esz + b] = hi[(e - n)*esz + b];
        else                r[i*esz + b] = 1'b0;
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld <= 1'b0;
      exp_res <= '0;
      exp_tag <= "R9";
    end else begin
      exp_vld <= op_valid;
      exp_tag <= cur_tag;
      if (op_valid)
        exp_res <= model(ew_sel, int'(ofs_from_reg ? reg_ofs : imm_ofs), src_lo, src_hi);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (res_valid !== exp_vld || res !== exp_res) begin
        n_bad++;
        $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h",
                 exp_tag, res_valid, res, exp_vld, exp_res);
      end
    end
  end

  task automatic op(input logic [1:0] w, input bit fr, input int imm, input int rg,
                    input logic [VLEN-1:0] lo, input logic [VLEN-1:0] hi, input string tag);
    @(negedge clk);
    op_valid     = 1'b1;
    ew_sel       = w;
    ofs_from_reg = fr;
    imm_ofs      = OFS_W'(imm);
    reg_ofs      = OFS_W'(rg);
    src_lo       = lo;
    src_hi       = hi;
    cur_tag      = tag;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    op_valid = 1'b0;
    src_lo   = {4{$urandom()}};
    src_hi   = {4{$urandom()}};
    imm_ofs  = OFS_W'($urandom());
    cur_tag  = tag;
  endtask

  function automatic logic [VLEN-1:0] ramp(input int base);
    logic [VLEN-1:0] v;
    for (int b = 0; b < NB; b++) v[b*8 +: 8] = 8'(base + b);
    return v;
  endfunction

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] lo;
    logic [VLEN-1:0] hi;
    rst_n = 1'b0; op_valid = 1'b0; ew_sel = 2'd0; ofs_from_reg = 1'b0;
    imm_ofs = '0; reg_ofs = '0; src_lo = '0; src_hi = '0;
    repeat (2) @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || res !== '0) begin
      n_bad++;
      $display("FAIL R9: valid=%0b res=%h expected valid=0 res=0", res_valid, res);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;
    lo = ramp(8'h00);
    hi = ramp(8'h10);
    // corner offsets for each width
    for (int w = 0; w < 4; w++) begin
      int n;
      n = (w == 0) ? 16 : (w == 1) ? 8 : 4;
      op(2'(w), 1'b0, 0,     99, lo, hi, "R2");
      op(2'(w), 1'b0, n,     0,  lo, hi, "R3");
      op(2'(w), 1'b0, 1,     0,  lo, hi, "R1");
      op(2'(w), 1'b0, n - 1, 0,  lo, hi, "R5");
      op(2'(w), 1'b0, 2*n-1, 0,  lo, hi, "R4");
      op(2'(w), 1'b0, 2*n,   0,  lo, hi, "R4");
      op(2'(w), 1'b0, 255,   0,  lo, hi, "R4");
      idle("R8");
      idle("R7");
    end
    // offset source selection with distinct unused value
    op(2'd0, 1'b1, 0, 3, lo, hi, "R6");
    op(2'd1, 1'b1, 5, 0, lo, hi, "R6");
    op(2'd2, 1'b0, 2, 7, lo, hi, "R6");
    idle("R8");
    // random patterns, back to back and with gaps
    for (int t = 0; t < 300; t++) begin
      lo = {$urandom(), $urandom(), $urandom(), $urandom()};
      hi = {$urandom(), $urandom(), $urandom(), $urandom()};
      op(2'($urandom_range(0, 3)), 1'($urandom()), $urandom_range(0, 40),
         $urandom_range(0, 40), lo, hi, "R1");
      if (t % 7 == 0) idle("R8");
    end
    idle("R7");
    idle("R7");
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule